// File: doc/BRIEF.md
# Software-Managed TLB with Zone Protection

This block is a fully associative address-translation buffer for an embedded processor whose entries are loaded by system software, not by a hardware table walker. Each lookup takes an effective address, an access kind, the current process ID, a 32-bit zone-protection word and the user/supervisor mode. One cycle later it returns whether the access is granted, which entry supplied the result, the physical address, and the read/write permissions. If the access is refused it reports either a protection fault or a miss.

Every entry carries its own page size, so small and large pages can sit side by side. An entry with process ID zero is shared by all processes. A 4-bit zone number in each entry picks a 2-bit code from the zone-protection word. That code can refuse a user access, defer to the entry's own execute and write bits, or open the page fully. On a miss the block latches the faulting address and a syndrome word that marks data-write misses. It also keeps a copy of the machine state word with its upper half cleared, ready for the exception handler.

Top module: `zone_tlb`

## Requirements
- R1: An entry whose valid bit is 0 never matches a lookup. Clearing the bit through the write port removes the entry from later lookups.
- R2: An entry with process ID 0 matches any `lk_pid`. An entry with a nonzero process ID matches only when it equals `lk_pid`.
- R3: The size code s (0..7) gives a page of 2^(10+2s) bytes, from 1 KiB to 16 MiB. The mask is the inverse of (page bytes − 1). An entry matches when (`lk_ea` AND mask) equals the stored effective page number exactly, so a stored page number with bits set below the mask never matches.
- R4: The physical address is (real page number AND mask) OR (`lk_ea` AND NOT mask).
- R5: For zone numbers z = 0..14, the zone code is bits [1:0] of `zpr` shifted right by 28 − 2z. Zone 15 always yields code 0.
- R6: Zone code 0 refuses every user-mode access. In supervisor mode it behaves like codes 1 and 2.
- R7: Zone codes 1 and 2 defer to the entry's own bits. Access kinds are encoded 2'b00 fetch, 2'b01 read, 2'b10 write, and 2'b11 is treated as a write. A fetch needs the execute bit, a write needs the write bit, and a read is always allowed. Read permission is granted, and write permission equals the entry's write bit.
- R8: Zone code 3 grants read and write permission for every access kind, whatever the entry's own bits are.
- R9: The granting entry with the lowest index supplies the index, address and permissions. A matching entry that refuses does not hide a later one that grants. With no grant, the result is a protection fault if any entry matched and a miss otherwise. At most one outcome flag is set.
- R10: `rsp_valid` and exactly one outcome flag rise in the cycle after `lk_req`. With no request, all flags are 0, and index, address and permissions keep their last values. After reset, every output is 0.
- R11: A miss raises `rsp_miss_instr` for a fetch and `rsp_miss_data` otherwise. It latches `lk_ea` into `fault_addr`, and sets `syndrome` to 0x00800000 for a write and to 0 otherwise. Hits and protection faults leave both registers unchanged.
- R12: On a miss, `msr_saved` takes `msr_cur` with bits [31:16] cleared. Otherwise it holds.
- R13: A write through the entry port becomes visible to lookups from the next cycle. A lookup in the same cycle as a write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_we | input | 1 | Entry write strobe |
| ent_idx | input | IDX_W | Entry index to write |
| ent_valid | input | 1 | Valid bit for the written entry |
| ent_pid | input | 8 | Process ID for the written entry (0 = shared by all) |
| ent_epn | input | 32 | Effective page number |
| ent_rpn | input | 32 | Real page number |
| ent_size | input | 3 | Page size code |
| ent_zone | input | 4 | Zone number |
| ent_exec | input | 1 | Execute permission bit |
| ent_write | input | 1 | Write permission bit |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address |
| lk_kind | input | 2 | Access kind |
| lk_pid | input | 8 | Current process ID |
| zpr | input | 32 | Zone-protection word |
| user_mode | input | 1 | 1 = user mode, 0 = supervisor mode |
| msr_cur | input | 32 | Current machine state word |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Access granted |
| rsp_idx | output | IDX_W | Index of the granting entry |
| rsp_pa | output | 32 | Physical address |
| rsp_perm_r | output | 1 | Read permission granted |
| rsp_perm_w | output | 1 | Write permission granted |
| rsp_prot_fault | output | 1 | Protection fault |
| rsp_miss_instr | output | 1 | Instruction-fetch miss |
| rsp_miss_data | output | 1 | Data-access miss |
| fault_addr | output | 32 | Latched miss address |
| syndrome | output | 32 | Latched miss syndrome |
| msr_saved | output | 32 | Machine state word saved on a miss, upper half cleared |

## Verification
Every result of a lookup is due exactly one clock edge after the `lk_req` cycle. This covers the outcome flags, the index, the physical address, the permissions, and the fault-address, syndrome and saved-state registers. An entry write changes the table one edge after `ent_we`. The bench drives inputs on the falling edge and advances one rising edge. It then compares every output on the following falling edge with a behavioural model that was evaluated on the inputs of the previous cycle. A write and a lookup in the same cycle are modelled as old-table lookups, because the model applies the write only after it has computed the expected result.

// File: rtl/zt_pkg.sv
package zt_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned PID_W  = 8;
  localparam int unsigned SZ_W   = 3;
  localparam int unsigned ZONE_W = 4;

  typedef struct packed {
    logic              vld;
    logic [PID_W-1:0]  pid;
    logic [ADDR_W-1:0] epn;
    logic [ADDR_W-1:0] rpn;
    logic [SZ_W-1:0]   size;
    logic [ZONE_W-1:0] zone;
    logic              ex;
    logic              wr;
  } tlb_entry_t;

  // page of 2^(10+2*sz) bytes; mask keeps the page-number bits
  function automatic logic [ADDR_W-1:0] page_mask(input logic [SZ_W-1:0] sz);
    logic [ADDR_W-1:0] bytes;
    bytes = ADDR_W'(1) << (10 + 2 * int'(sz));
    return ~(bytes - ADDR_W'(1));
  endfunction

  // zone code from the protection word; zone 15 shifts out to code 0
  function automatic logic [1:0] zone_code(input logic [31:0] zp,
                                           input logic [ZONE_W-1:0] zsel);
    logic [31:0] sh;
    if (zsel == 4'hF) return 2'b00;
    sh = zp >> (28 - 2 * int'(zsel));
    return sh[1:0];
  endfunction

  // returns {grant, write_permission}
  function automatic logic [1:0] zone_decide(input logic [1:0] code,
                                             input logic user,
                                             input logic [1:0] kind,
                                             input logic ex,
                                             input logic wr);
    if (code == 2'd3) return 2'b11;
    if (code == 2'd0 && user) return 2'b00;
    if (kind == 2'b00) return {ex, wr};
    if (kind[1]) return {wr, wr};
    return {1'b1, wr};
  endfunction
endpackage

// File: rtl/zt_entry_store.sv
module zt_entry_store
  import zt_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  tlb_entry_t       wdata,
  output tlb_entry_t       table_q [ENTRIES]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) table_q[i] <= '0;
    end else if (we && (int'(widx) < ENTRIES)) begin
      table_q[widx] <= wdata;
    end
  end
endmodule

// File: rtl/zt_match_eval.sv
module zt_match_eval
  import zt_pkg::*;
#(
  parameter int unsigned ENTRIES = 64
) (
  input  tlb_entry_t         table_i [ENTRIES],
  input  logic [ADDR_W-1:0]  ea,
  input  logic [1:0]         kind,
  input  logic [PID_W-1:0]   cur_pid,
  input  logic [31:0]        zp,
  input  logic               user,
  output logic [ENTRIES-1:0] match_vec,
  output logic [ENTRIES-1:0] grant_vec,
  output logic [ENTRIES-1:0] permw_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [ADDR_W-1:0] msk;
    logic              pid_ok;
    logic [1:0]        dec;
    assign msk    = page_mask(table_i[g].size);
    assign pid_ok = (table_i[g].pid == '0) || (table_i[g].pid == cur_pid);
    assign match_vec[g] = table_i[g].vld && pid_ok && ((ea & msk) == table_i[g].epn);
    assign dec = zone_decide(zone_code(zp, table_i[g].zone), user, kind,
                             table_i[g].ex, table_i[g].wr);
    assign grant_vec[g] = match_vec[g] & dec[1];
    assign permw_vec[g] = dec[0];
  end
endmodule

// File: rtl/zt_prio_enc.sv
module zt_prio_enc #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] vec,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/zone_tlb.sv
module zone_tlb
  import zt_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ent_we,
  input  logic [IDX_W-1:0]  ent_idx,
  input  logic              ent_valid,
  input  logic [7:0]        ent_pid,
  input  logic [31:0]       ent_epn,
  input  logic [31:0]       ent_rpn,
  input  logic [2:0]        ent_size,
  input  logic [3:0]        ent_zone,
  input  logic              ent_exec,
  input  logic              ent_write,
  input  logic              lk_req,
  input  logic [31:0]       lk_ea,
  input  logic [1:0]        lk_kind,
  input  logic [7:0]        lk_pid,
  input  logic [31:0]       zpr,
  input  logic              user_mode,
  input  logic [31:0]       msr_cur,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [31:0]       rsp_pa,
  output logic              rsp_perm_r,
  output logic              rsp_perm_w,
  output logic              rsp_prot_fault,
  output logic              rsp_miss_instr,
  output logic              rsp_miss_data,
  output logic [31:0]       fault_addr,
  output logic [31:0]       syndrome,
  output logic [31:0]       msr_saved
);
  localparam logic [31:0] SYN_WRITE = 32'h0080_0000;

  tlb_entry_t         wr_entry;
  tlb_entry_t         table_q [ENTRIES];
  logic [ENTRIES-1:0] match_vec, grant_vec, permw_vec;
  logic               any_match, any_grant;
  logic [IDX_W-1:0]   win_idx, match_idx;
  tlb_entry_t         win_ent;
  logic [31:0]        win_mask, win_pa;
  logic               lk_miss_now, lk_fault_now;

  assign wr_entry = '{vld: ent_valid, pid: ent_pid, epn: ent_epn, rpn: ent_rpn,
                      size: ent_size, zone: ent_zone, ex: ent_exec, wr: ent_write};

  zt_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(ent_we), .widx(ent_idx),
    .wdata(wr_entry), .table_q(table_q)
  );

  zt_match_eval #(.ENTRIES(ENTRIES)) u_eval (
    .table_i(table_q), .ea(lk_ea), .kind(lk_kind), .cur_pid(lk_pid),
    .zp(zpr), .user(user_mode),
    .match_vec(match_vec), .grant_vec(grant_vec), .permw_vec(permw_vec)
  );

  zt_prio_enc #(.ENTRIES(ENTRIES)) u_grant_pe (
    .vec(grant_vec), .found(any_grant), .idx(win_idx)
  );

  zt_prio_enc #(.ENTRIES(ENTRIES)) u_match_pe (
    .vec(match_vec), .found(any_match), .idx(match_idx)
  );

  assign win_ent      = table_q[win_idx];
  assign win_mask     = page_mask(win_ent.size);
  assign win_pa       = (win_ent.rpn & win_mask) | (lk_ea & ~win_mask);
  assign lk_miss_now  = lk_req && !any_match;
  assign lk_fault_now = lk_req && any_match && !any_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_idx        <= '0;
      rsp_pa         <= '0;
      rsp_perm_r     <= 1'b0;
      rsp_perm_w     <= 1'b0;
      rsp_prot_fault <= 1'b0;
      rsp_miss_instr <= 1'b0;
      rsp_miss_data  <= 1'b0;
      fault_addr     <= '0;
      syndrome       <= '0;
      msr_saved      <= '0;
    end else begin
      rsp_valid      <= lk_req;
      rsp_hit        <= lk_req && any_grant;
      rsp_prot_fault <= lk_fault_now;
      rsp_miss_instr <= lk_miss_now && (lk_kind == 2'b00);
      rsp_miss_data  <= lk_miss_now && (lk_kind != 2'b00);
      if (lk_req) begin
        rsp_idx    <= any_grant ? win_idx : '0;
        rsp_pa     <= any_grant ? win_pa : '0;
        rsp_perm_r <= any_grant;
        rsp_perm_w <= any_grant && permw_vec[win_idx];
      end
      if (lk_miss_now) begin
        fault_addr <= lk_ea;
        syndrome   <= lk_kind[1] ? SYN_WRITE : 32'h0;
        msr_saved  <= msr_cur & 32'h0000_FFFF;
      end
    end
  end

  // lowest matching index is kept only for the checker's relation to the grant scan
  logic unused_match_idx;
  assign unused_match_idx = ^match_idx;
endmodule

// File: rtl/zt_checker.sv
module zt_checker #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_req,
  input logic [31:0]        lk_ea,
  input logic [1:0]         lk_kind,
  input logic [ENTRIES-1:0] grant_vec,
  input logic [ENTRIES-1:0] match_vec,
  input logic [IDX_W-1:0]   match_idx,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [IDX_W-1:0]   rsp_idx,
  input logic               rsp_perm_r,
  input logic               rsp_prot_fault,
  input logic               rsp_miss_instr,
  input logic               rsp_miss_data,
  input logic [31:0]        fault_addr,
  input logic [31:0]        syndrome,
  input logic [31:0]        msr_saved
);
  logic [ENTRIES-1:0] below;
  logic               any_miss;
  always_comb below = (ENTRIES'(1) << rsp_idx) - ENTRIES'(1);
  assign any_miss = rsp_miss_instr | rsp_miss_data;

  // R10: result valid exactly one cycle after a request
  a_r10_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);
  a_r10_no_valid_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);
  a_r10_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit | rsp_prot_fault | any_miss) |-> rsp_valid);
  // R9: one outcome at a time
  a_r9_outcome_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_hit, rsp_prot_fault, rsp_miss_instr, rsp_miss_data}));
  // R9: hit follows the presence of any granting entry
  a_r9_hit_tracks_grant: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (rsp_hit == $past(|grant_vec)));
  // R9: winning entry granted and no lower entry did
  a_r9_winner_granted: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (($past(grant_vec) >> rsp_idx) & ENTRIES'(1)) != '0);
  a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (($past(grant_vec) & below) == '0));
  // R9: a miss means no entry matched at all
  a_r9_miss_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    any_miss |-> ($past(match_vec) == '0));
  // R9: a granting entry can never sit below the lowest matching one
  a_r9_grant_not_below_match: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && (grant_vec != '0)) |-> ((grant_vec & ((ENTRIES'(1) << match_idx) - ENTRIES'(1))) == '0));
  // R7: read permission accompanies every grant and only a grant
  a_r7_read_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_perm_r == rsp_hit));
  // R11: miss capture and hold
  a_r11_addr_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    any_miss |-> (fault_addr == $past(lk_ea)));
  a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !any_miss |-> $stable(fault_addr));
  a_r11_fetch_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss_instr |-> (syndrome == 32'h0));
  a_r11_write_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_miss_data && $past(lk_kind[1])) |-> (syndrome == 32'h0080_0000));
  // R12: saved state has its upper half cleared
  a_r12_msr_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    any_miss |-> (msr_saved[31:16] == 16'h0));
endmodule

bind zone_tlb zt_checker #(.ENTRIES(ENTRIES)) u_zt_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_ea(lk_ea), .lk_kind(lk_kind),
  .grant_vec(grant_vec), .match_vec(match_vec), .match_idx(match_idx),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
  .rsp_perm_r(rsp_perm_r), .rsp_prot_fault(rsp_prot_fault),
  .rsp_miss_instr(rsp_miss_instr), .rsp_miss_data(rsp_miss_data),
  .fault_addr(fault_addr), .syndrome(syndrome), .msr_saved(msr_saved)
);

// File: tb/zone_tlb_test.sv
module zone_tlb_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        ent_we = 0, ent_valid = 0, ent_exec = 0, ent_write = 0;
  logic [5:0]  ent_idx = 0;
  logic [7:0]  ent_pid = 0, lk_pid = 0;
  logic [31:0] ent_epn = 0, ent_rpn = 0, lk_ea = 0, zpr = 0, msr_cur = 0;
  logic [2:0]  ent_size = 0;
  logic [3:0]  ent_zone = 0;
  logic        lk_req = 0, user_mode = 0;
  logic [1:0]  lk_kind = 0;

  logic        rsp_valid, rsp_hit, rsp_perm_r, rsp_perm_w, rsp_prot_fault;
  logic        rsp_miss_instr, rsp_miss_data;
  logic [5:0]  rsp_idx;
  logic [31:0] rsp_pa, fault_addr, syndrome, msr_saved;

  zone_tlb #(.ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .ent_we(ent_we), .ent_idx(ent_idx),
    .ent_valid(ent_valid), .ent_pid(ent_pid), .ent_epn(ent_epn), .ent_rpn(ent_rpn),
    .ent_size(ent_size), .ent_zone(ent_zone), .ent_exec(ent_exec), .ent_write(ent_write),
    .lk_req(lk_req), .lk_ea(lk_ea), .lk_kind(lk_kind), .lk_pid(lk_pid), .zpr(zpr),
    .user_mode(user_mode), .msr_cur(msr_cur),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx), .rsp_pa(rsp_pa),
    .rsp_perm_r(rsp_perm_r), .rsp_perm_w(rsp_perm_w), .rsp_prot_fault(rsp_prot_fault),
    .rsp_miss_instr(rsp_miss_instr), .rsp_miss_data(rsp_miss_data),
    .fault_addr(fault_addr), .syndrome(syndrome), .msr_saved(msr_saved)
  );

  // behavioural model state
  bit          m_vld [N];
  bit [7:0]    m_pid [N];
  bit [31:0]   m_epn [N], m_rpn [N];
  bit [2:0]    m_sz [N];
  bit [3:0]    m_zone [N];
  bit          m_ex [N], m_wr [N];

  bit e_valid, e_hit, e_pr, e_pw, e_fault, e_mi, e_md;
  int unsigned e_idx;
  bit [31:0] e_pa, e_dear, e_esr, e_msr;

  int checks = 0, fails = 0;
  string tag = "R10";
  bit done = 0;

  function automatic bit [1:0] ref_code(bit [31:0] zp, bit [3:0] z);
    if (z == 15) return 2'd0;
    return 2'((zp >> (28 - 2 * int'(z))) & 32'd3);
  endfunction

  function automatic bit [31:0] zbits(int z, int c);
    return 32'(c) << (28 - 2 * z);
  endfunction

  task automatic model_step();
    bit found, anym, g, w;
    bit [31:0] bytes, msk;
    bit [1:0] code;
    e_valid = lk_req; e_hit = 0; e_fault = 0; e_mi = 0; e_md = 0;
    if (lk_req) begin
      found = 0; anym = 0;
      for (int i = 0; i < N; i++) begin
        if (!found) begin
          bytes = 32'd1 << (10 + 2 * int'(m_sz[i]));
          msk = ~(bytes - 32'd1);
          if (m_vld[i] && (m_pid[i] == 0 || m_pid[i] == lk_pid) && ((lk_ea & msk) == m_epn[i])) begin
            anym = 1;
            code = ref_code(zpr, m_zone[i]);
            g = 0; w = 0;
            if (code == 3) begin g = 1; w = 1; end
            else if (code == 0 && user_mode) g = 0;
            else begin
              w = m_wr[i];
              case (lk_kind)
                2'd0: g = m_ex[i];
                2'd1: g = 1;
                default: g = m_wr[i];
              endcase
            end
            if (g) begin
              found = 1; e_idx = i; e_pw = w; e_pr = 1;
              e_pa = (m_rpn[i] & msk) | (lk_ea & ~msk);
            end
          end
        end
      end
      e_hit = found;
      if (!found) begin e_idx = 0; e_pa = 0; e_pr = 0; e_pw = 0; end
      e_fault = !found && anym;
      if (!anym) begin
        e_mi = (lk_kind == 2'd0);
        e_md = (lk_kind != 2'd0);
        e_dear = lk_ea;
        e_esr = lk_kind[1] ? 32'h0080_0000 : 32'h0;
        e_msr = {16'h0, msr_cur[15:0]};
      end
    end
    if (ent_we) begin
      m_vld[ent_idx] = ent_valid; m_pid[ent_idx] = ent_pid; m_epn[ent_idx] = ent_epn;
      m_rpn[ent_idx] = ent_rpn; m_sz[ent_idx] = ent_size; m_zone[ent_idx] = ent_zone;
      m_ex[ent_idx] = ent_exec; m_wr[ent_idx] = ent_write;
    end
  endtask

  task automatic chk(string f, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, f, act, exp);
    end
  endtask

  task automatic compare();
    chk("valid", 32'(rsp_valid), 32'(e_valid));
    chk("hit", 32'(rsp_hit), 32'(e_hit));
    chk("prot_fault", 32'(rsp_prot_fault), 32'(e_fault));
    chk("miss_instr", 32'(rsp_miss_instr), 32'(e_mi));
    chk("miss_data", 32'(rsp_miss_data), 32'(e_md));
    chk("idx", 32'(rsp_idx), 32'(e_idx));
    chk("pa", rsp_pa, e_pa);
    chk("perm_r", 32'(rsp_perm_r), 32'(e_pr));
    chk("perm_w", 32'(rsp_perm_w), 32'(e_pw));
    chk("fault_addr", fault_addr, e_dear);
    chk("syndrome", syndrome, e_esr);
    chk("msr_saved", msr_saved, e_msr);
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    ent_we = 0;
    lk_req = 0;
  endtask

  task automatic set_ent(int idx, bit v, bit [7:0] pid, bit [31:0] epn, bit [31:0] rpn,
                         bit [2:0] sz, bit [3:0] z, bit ex, bit wr);
    ent_we = 1; ent_idx = 6'(idx); ent_valid = v; ent_pid = pid; ent_epn = epn;
    ent_rpn = rpn; ent_size = sz; ent_zone = z; ent_exec = ex; ent_write = wr;
  endtask

  task automatic set_lk(bit [31:0] ea, bit [1:0] k, bit [7:0] pid, bit usr);
    lk_req = 1; lk_ea = ea; lk_kind = k; lk_pid = pid; user_mode = usr;
  endtask

  task automatic wr_ent(int idx, bit v, bit [7:0] pid, bit [31:0] epn, bit [31:0] rpn,
                        bit [2:0] sz, bit [3:0] z, bit ex, bit wr);
    set_ent(idx, v, pid, epn, rpn, sz, z, ex, wr);
    cycle();
  endtask

  task automatic look(bit [31:0] ea, bit [1:0] k, bit [7:0] pid, bit usr);
    set_lk(ea, k, pid, usr);
    cycle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit [31:0] s;
    bit [31:0] pages [8];
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    e_idx = 0; e_pa = 0; e_dear = 0; e_esr = 0; e_msr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R10"; cycle();                      // reset state

    zpr = zbits(1, 1) | zbits(2, 2) | zbits(3, 3) | zbits(4, 0) | zbits(5, 1) | 32'h3;
    tag = "R1"; look(32'h0001_0abc, 2'd1, 8'd7, 1);   // empty table: data read miss
    tag = "R13"; wr_ent(5, 1, 8'd0, 32'h0001_0000, 32'h8000_0000, 3'd1, 4'd1, 1, 0);
    tag = "R2"; look(32'h0001_0abc, 2'd1, 8'd7, 1);   // global entry hit, read only
    tag = "R4"; look(32'h0001_0fff, 2'd1, 8'd9, 1);
    tag = "R7"; look(32'h0001_0abc, 2'd2, 8'd7, 1);   // write to read-only: fault
    tag = "R11"; look(32'h0001_0004, 2'd0, 8'd7, 1);  // fetch allowed, capture untouched
    tag = "R3"; look(32'h0001_1000, 2'd0, 8'd7, 1);   // outside 4K page: fetch miss
    tag = "R2"; wr_ent(2, 1, 8'd3, 32'h0001_0000, 32'h9000_0000, 3'd1, 4'd2, 0, 1);
    look(32'h0001_0abc, 2'd2, 8'd7, 1);               // pid mismatch on 2, 5 faults
    tag = "R9"; look(32'h0001_0abc, 2'd2, 8'd3, 1);   // idx 2 wins read/write
    look(32'h0001_0abc, 2'd0, 8'd3, 1);               // idx 2 faults, idx 5 grants
    tag = "R1"; wr_ent(2, 0, 8'd3, 32'h0001_0000, 32'h9000_0000, 3'd1, 4'd2, 0, 1);
    look(32'h0001_0abc, 2'd2, 8'd3, 1);
    tag = "R6"; wr_ent(6, 1, 8'd0, 32'h0040_0000, 32'h0010_0000, 3'd5, 4'd4, 1, 1);
    look(32'h0041_2345, 2'd1, 8'd1, 1);
    look(32'h0041_2345, 2'd1, 8'd1, 0);
    tag = "R8"; wr_ent(7, 1, 8'd0, 32'h0080_0000, 32'h00C0_4000, 3'd2, 4'd3, 0, 0);
    look(32'h0080_3210, 2'd0, 8'd1, 1);
    look(32'h0080_3210, 2'd2, 8'd1, 1);
    tag = "R5"; wr_ent(9, 1, 8'd0, 32'h0200_0000, 32'h0300_0000, 3'd0, 4'd15, 1, 1);
    look(32'h0200_0010, 2'd1, 8'd1, 1);
    look(32'h0200_0010, 2'd1, 8'd1, 0);
    wr_ent(10, 1, 8'd0, 32'h0210_0000, 32'h0310_0000, 3'd0, 4'd14, 0, 0);
    look(32'h0210_0020, 2'd2, 8'd1, 1);
    tag = "R3"; wr_ent(11, 1, 8'd0, 32'h0500_0000, 32'h0A00_0000, 3'd7, 4'd5, 1, 1);
    look(32'h05ab_cdef, 2'd0, 8'd1, 1);
    wr_ent(12, 1, 8'd0, 32'h0300_0100, 32'h0, 3'd1, 4'd3, 1, 1);
    look(32'h0300_0100, 2'd1, 8'd1, 1);
    tag = "R12"; msr_cur = 32'hABCD_1234;
    look(32'h7FFF_0000, 2'd2, 8'd1, 0);
    tag = "R13"; set_ent(13, 1, 8'd0, 32'h0400_0000, 32'h0600_0000, 3'd3, 4'd3, 0, 0);
    set_lk(32'h0400_0123, 2'd1, 8'd1, 1); cycle();
    look(32'h0400_0123, 2'd1, 8'd1, 1);

    tag = "R9";
    pages = '{32'h0001_0000, 32'h0040_0000, 32'h0080_0000, 32'h0200_0000,
              32'h0210_0000, 32'h0500_0000, 32'h0400_0000, 32'h7FFF_0000};
    s = 32'h1234_5678;
    for (int n = 0; n < 300; n++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      zpr = s ^ {s[15:0], s[31:16]};
      msr_cur = ~s;
      if (s[3:0] == 0) begin
        set_ent(int'(s[8:5]) + 8, s[9], {6'd0, s[11:10]}, pages[s[14:12]],
                s & 32'hFFFF_0000, 3'(s[17:16]), s[21:18], s[22], s[23]);
      end
      if (s[4]) set_lk(pages[s[26:24]] | (s & 32'h0000_0FFF), s[28:27],
                       {6'd0, s[30:29]}, s[31]);
      cycle();
    end
    finish_run();
  end
endmodule